// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This block keeps the interrupt bookkeeping of an SD host controller. Single-cycle event strobes from the command engine, the data path and the card-detect logic set sticky bits in a raw status word. A mask and a global enable combine that word into one registered interrupt line. Software clears bits by writing ones to the raw or masked status offset. The block also tracks a card-present flag.

A byte-transfer counter is loaded whenever software writes the byte-count register. Each 4-byte FIFO access reported on `fifo_access` lowers the counter by four, stopping at zero. The access that brings the counter to zero raises the data-complete bit on its own, so FIFO-driven transfers finish without a separate strobe.

The register port is a plain 32-bit synchronous write, asynchronous read port with byte offsets: 0x00 global control, 0x04 byte count, 0x08 mask, 0x0C masked status, 0x10 raw status, 0x14 status.

Top module: `sdh_irq_unit`

## Requirements
- R1: After reset, global control reads 0x300, byte count 0x200, mask 0, raw status 0, masked status 0, status 0x100 (card present, bit 8), and `irq` is low.
- R2: Each event strobe sets its own raw status bit at the next clock edge: bit 1 no response, bit 2 command complete, bit 3 data complete, bit 14 auto-command done, bit 16 SDIO interrupt. Bits already set stay set.
- R3: A write to offset 0x10 or 0x0C clears every raw status bit written as 1 and leaves the others unchanged.
- R4: When an event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x0C returns raw status AND mask.
- R6: `irq` is a register. It equals (raw status AND mask) being non-zero while global-control bit 4 is 1, and it is 0 while bit 4 is 0. It follows any change one clock after the change reaches the registers.
- R7: A card-insert strobe sets raw bit 30, clears raw bit 31 and sets status bit 8. A card-remove strobe sets bit 31, clears bit 30 and clears status bit 8. If both arrive together, insert wins.
- R8: A byte-count write loads the transfer counter. A FIFO access lowers the counter by 4 and stops at 0. Any FIFO access made while the counter is 4 or less sets raw bit 3. A byte-count write in the same cycle as a FIFO access takes precedence.
- R9: Global-control bits 2, 1 and 0 always read 0. All other written bits read back as written.
- R10: Raw status bits other than 1, 2, 3, 14, 16, 30 and 31 always read 0. Writes to the status offset and to unknown offsets change nothing, and unknown offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| fifo_access | input | 1 | One 4-byte FIFO word moved |
| ev_cmd_done | input | 1 | Command complete strobe |
| ev_no_resp | input | 1 | No response strobe |
| ev_data_done | input | 1 | Data complete strobe |
| ev_autocmd_done | input | 1 | Auto-command done strobe |
| ev_sdio | input | 1 | SDIO interrupt strobe |
| ev_card_insert | input | 1 | Card inserted strobe |
| ev_card_remove | input | 1 | Card removed strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
Register writes, event strobes and FIFO accesses all land at the same clock edge. Their effect can therefore be read back on the port one cycle after the stimulus is driven. `irq` is a second register stage, so it is due one edge later still.

The bench drives every stimulus on a falling edge and reads back at the next falling edge. At that point it first confirms that `irq` has not moved yet, then waits one more cycle and confirms the new level. The counter is checked at each decrement step on both sides of zero.

// File: rtl/sdh_irq_pkg.sv
// Package: shared widths, bit positions and register offsets for the SD host
// interrupt unit. Assumes byte-addressed 32-bit registers.
package sdh_irq_pkg;
    localparam int REG_W = 32;
    localparam int ADDR_W = 8;

    // raw status bit positions (decoded by software, so fixed)
    localparam int B_NO_RESP  = 1;
    localparam int B_CMD_DONE = 2;
    localparam int B_DATA_DONE = 3;
    localparam int B_ACMD_DONE = 14;
    localparam int B_SDIO     = 16;
    localparam int B_CARD_IN  = 30;
    localparam int B_CARD_OUT = 31;

    localparam int GC_IRQ_EN   = 4;
    localparam int GC_SELF_CLR = 3;   // number of self-clearing low bits
    localparam int ST_PRESENT  = 8;

    localparam logic [REG_W-1:0] GCTL_RST = 32'h0000_0300;
    localparam logic [REG_W-1:0] BCNT_RST = 32'h0000_0200;

    localparam logic [ADDR_W-1:0] OFS_GCTL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_BCNT   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;

    // set of raw status bits that exist
    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_NO_RESP] = 1'b1;
        m[B_CMD_DONE] = 1'b1;
        m[B_DATA_DONE] = 1'b1;
        m[B_ACMD_DONE] = 1'b1;
        m[B_SDIO] = 1'b1;
        m[B_CARD_IN] = 1'b1;
        m[B_CARD_OUT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sdh_irq_ctrl_regs.sv
// Module: software control registers (global control, mask, byte count).
// Assumes one write per cycle. The low self-clearing global-control bits are
// never stored.
module sdh_irq_ctrl_regs
    import sdh_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gctl_we,
    input  logic         mask_we,
    input  logic         bcnt_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] gctl_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] bcnt_q
);
    localparam logic [W-1:0] SELF_CLR_BITS = W'((1 << GC_SELF_CLR) - 1);

    // register updates for the three control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= W'(GCTL_RST);
            mask_q <= '0;
            bcnt_q <= W'(BCNT_RST);
        end else begin
            if (gctl_we) gctl_q <= wdata & ~SELF_CLR_BITS;
            if (mask_we) mask_q <= wdata;
            if (bcnt_we) bcnt_q <= wdata;
        end
    end
endmodule

// File: rtl/sdh_irq_xfer_cnt.sv
// Module: remaining-byte counter for FIFO transfers. A load has precedence
// over a step. A step at or below STEP saturates at zero and flags completion.
module sdh_irq_xfer_cnt #(
    parameter int CNT_W = 32,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic             reach_zero
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    // completion flag: a step that ends at zero
    always_comb reach_zero = step && !load && (cnt_q <= STEP_V);

    // counter update with saturation
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (step)       cnt_q <= (cnt_q > STEP_V) ? cnt_q - STEP_V : '0;
    end
endmodule

// File: rtl/sdh_irq_raw_status.sv
// Module: sticky raw interrupt status and card-present flag. Event sets win
// over same-cycle clears. Card insert wins over card remove. Bits outside
// the implemented set are held at zero.
module sdh_irq_raw_status
    import sdh_irq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         card_in,
    input  logic         card_out,
    output logic [W-1:0] raw_q,
    output logic         present_q
);
    localparam logic [W-1:0] IMPL = W'(impl_mask());

    logic [W-1:0] raw_nxt;

    // next raw word: clear first, then events, then card pair
    always_comb begin
        raw_nxt = (raw_q & ~clr_vec) | set_vec;
        if (card_in) begin
            raw_nxt[B_CARD_IN]  = 1'b1;
            raw_nxt[B_CARD_OUT] = 1'b0;
        end else if (card_out) begin
            raw_nxt[B_CARD_IN]  = 1'b0;
            raw_nxt[B_CARD_OUT] = 1'b1;
        end
        raw_nxt = raw_nxt & IMPL;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q     <= '0;
            present_q <= 1'b1;
        end else begin
            raw_q <= raw_nxt;
            if (card_in)       present_q <= 1'b1;
            else if (card_out) present_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sdh_irq_out.sv
// Module: registered interrupt line. Assumes its inputs come straight from
// registers, so the line lags them by exactly one cycle.
module sdh_irq_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    output logic         irq
);
    // masked-or reduction into the output flop
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= enable && |(raw & mask);
    end
endmodule

// File: rtl/sdh_irq_unit.sv
// Module: top of the SD host interrupt status and mask unit. Decodes the
// register port, packs event strobes and drives the interrupt line.
// Assumes strobes are one cycle wide and the port does single-cycle writes.
module sdh_irq_unit
    import sdh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              fifo_access,
    input  logic              ev_cmd_done,
    input  logic              ev_no_resp,
    input  logic              ev_data_done,
    input  logic              ev_autocmd_done,
    input  logic              ev_sdio,
    input  logic              ev_card_insert,
    input  logic              ev_card_remove,
    output logic              irq
);
    logic [REG_W-1:0] gctl_q, mask_q, bcnt_q, raw_q, cnt_q;
    logic [REG_W-1:0] set_vec, clr_vec;
    logic             present_q, cnt_zero;
    logic             gctl_we, mask_we, bcnt_we;

    // write decode
    always_comb begin
        gctl_we = reg_wr_en && (reg_addr == OFS_GCTL);
        mask_we = reg_wr_en && (reg_addr == OFS_MASK);
        bcnt_we = reg_wr_en && (reg_addr == OFS_BCNT);
        clr_vec = (reg_wr_en && (reg_addr == OFS_RAW || reg_addr == OFS_MASKED))
                  ? reg_wdata : '0;
    end

    // event packing into raw bit positions
    always_comb begin
        set_vec = '0;
        set_vec[B_NO_RESP]   = ev_no_resp;
        set_vec[B_CMD_DONE]  = ev_cmd_done;
        set_vec[B_DATA_DONE] = ev_data_done | cnt_zero;
        set_vec[B_ACMD_DONE] = ev_autocmd_done;
        set_vec[B_SDIO]      = ev_sdio;
    end

    sdh_irq_ctrl_regs #(.W(REG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .gctl_we(gctl_we), .mask_we(mask_we),
        .bcnt_we(bcnt_we), .wdata(reg_wdata), .gctl_q(gctl_q),
        .mask_q(mask_q), .bcnt_q(bcnt_q)
    );

    sdh_irq_xfer_cnt #(.CNT_W(REG_W), .STEP(4)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(bcnt_we), .load_val(reg_wdata),
        .step(fifo_access), .cnt_q(cnt_q), .reach_zero(cnt_zero)
    );

    sdh_irq_raw_status #(.W(REG_W)) u_raw (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .card_in(ev_card_insert), .card_out(ev_card_remove),
        .raw_q(raw_q), .present_q(present_q)
    );

    sdh_irq_out #(.W(REG_W)) u_out (
        .clk(clk), .rst_n(rst_n), .enable(gctl_q[GC_IRQ_EN]),
        .raw(raw_q), .mask(mask_q), .irq(irq)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_GCTL:   reg_rdata = gctl_q;
            OFS_BCNT:   reg_rdata = bcnt_q;
            OFS_MASK:   reg_rdata = mask_q;
            OFS_MASKED: reg_rdata = raw_q & mask_q;
            OFS_RAW:    reg_rdata = raw_q;
            OFS_STATUS: reg_rdata[ST_PRESENT] = present_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdh_irq_unit_chk.sv
// Module: property checker for sdh_irq_unit, bound onto every instance.
module sdh_irq_unit_chk
    import sdh_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [REG_W-1:0] gctl_q,
    input logic [REG_W-1:0] mask_q,
    input logic [REG_W-1:0] raw_q,
    input logic [REG_W-1:0] cnt_q,
    input logic             present_q,
    input logic             ev_cmd_done,
    input logic             ev_card_insert,
    input logic             ev_card_remove,
    input logic             fifo_access,
    input logic             bcnt_we
);
    localparam logic [REG_W-1:0] IMPL = REG_W'(impl_mask());

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq == $past(gctl_q[GC_IRQ_EN] && |(raw_q & mask_q)));

    // R4
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_cmd_done) |-> raw_q[B_CMD_DONE]);

    // R7
    card_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_card_insert) |-> present_q && raw_q[B_CARD_IN] && !raw_q[B_CARD_OUT]);

    // R7
    card_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_card_remove && !ev_card_insert) |->
        !present_q && raw_q[B_CARD_OUT] && !raw_q[B_CARD_IN]);

    // R8
    cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_access && !bcnt_we && cnt_q <= 4) |->
        raw_q[B_DATA_DONE] && cnt_q == '0);

    // R9
    self_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gctl_q[2:0] == 3'b000);

    // R10
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q & ~IMPL) == '0);
endmodule

bind sdh_irq_unit sdh_irq_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .gctl_q(gctl_q), .mask_q(mask_q),
    .raw_q(raw_q), .cnt_q(cnt_q), .present_q(present_q),
    .ev_cmd_done(ev_cmd_done), .ev_card_insert(ev_card_insert),
    .ev_card_remove(ev_card_remove), .fifo_access(fifo_access),
    .bcnt_we(bcnt_we)
);

// File: tb/sdh_irq_unit_bench.sv
// Directed bench for sdh_irq_unit. Inputs change on falling edges and
// outputs are sampled on falling edges.
module sdh_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_access = 1'b0;
    logic [6:0]  ev = '0;   // {remove, insert, sdio, acmd, data, noresp, cmd}
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    sdh_irq_unit u_sdh_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_access(fifo_access),
        .ev_cmd_done(ev[0]), .ev_no_resp(ev[1]), .ev_data_done(ev[2]),
        .ev_autocmd_done(ev[3]), .ev_sdio(ev[4]), .ev_card_insert(ev[5]),
        .ev_card_remove(ev[6]), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one write cycle; returns at the falling edge after it took effect
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [6:0] e);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic fifo_step();
        fifo_access = 1'b1;
        @(negedge clk);
        fifo_access = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); chk("R1 gctl", d, 32'h300);
        rd(8'h04, d); chk("R1 bcnt", d, 32'h200);
        rd(8'h08, d); chk("R1 mask", d, 0);
        rd(8'h10, d); chk("R1 raw", d, 0);
        rd(8'h0C, d); chk("R1 masked", d, 0);
        rd(8'h14, d); chk("R1 status", d, 32'h100);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        pulse(7'b0000001); rd(8'h10, d); chk("R2 cmd bit2", d, 32'h4);
        pulse(7'b0011010); rd(8'h10, d); chk("R2 noresp/acmd/sdio sticky", d, 32'h0001_4006);
        pulse(7'b0000100); rd(8'h10, d); chk("R2 data bit3", d, 32'h0001_400E);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(8'h10, 32'h0000_4002); rd(8'h10, d); chk("R3 raw-offset clear", d, 32'h0001_000C);
        wr(8'h08, 32'h0000_0008);
        wr(8'h0C, 32'h0001_0004); rd(8'h10, d); chk("R3 masked-offset clear", d, 32'h8);
        rd(8'h0C, d); chk("R5 masked read", d, 32'h8);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R5 full mask", d, 32'h8);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h08, 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pulse(7'b0000011);
        ev = 7'b0000001; reg_wr_en = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h6;
        @(negedge clk);
        ev = '0; reg_wr_en = 1'b0;
        rd(8'h10, d); chk("R4 event beats clear", d, 32'h4);
        wr(8'h10, 32'h4);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(7'b0000001);
        wr(8'h08, 32'h4);
        chk("R6 irq off while disabled", {31'b0, irq}, 0);
        wr(8'h00, 32'h10);
        chk("R6 irq one cycle late", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R6 irq asserted", {31'b0, irq}, 1);
        wr(8'h08, 32'h0);
        chk("R6 irq holds one cycle", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R6 irq drops on mask", {31'b0, irq}, 0);
        wr(8'h08, 32'h4); @(negedge clk);
        chk("R6 irq back", {31'b0, irq}, 1);
        wr(8'h10, 32'h4); @(negedge clk);
        chk("R6 irq drops on clear", {31'b0, irq}, 0);
        wr(8'h00, 32'h0); wr(8'h08, 32'h0);
        rd(8'h00, d); chk("R6 enable off", d, 0);
    endtask

    task automatic t_card();
        logic [31:0] d;
        pulse(7'b1000000);
        rd(8'h10, d); chk("R7 remove raw", d, 32'h8000_0000);
        rd(8'h14, d); chk("R7 remove status", d, 0);
        pulse(7'b0100000);
        rd(8'h10, d); chk("R7 insert raw", d, 32'h4000_0000);
        rd(8'h14, d); chk("R7 insert status", d, 32'h100);
        pulse(7'b1000000);
        pulse(7'b1100000);
        rd(8'h10, d); chk("R7 insert wins raw", d, 32'h4000_0000);
        rd(8'h14, d); chk("R7 insert wins status", d, 32'h100);
        wr(8'h10, 32'hFFFF_FFFF);
    endtask

    task automatic t_counter();
        logic [31:0] d;
        wr(8'h04, 12);
        rd(8'h04, d); chk("R8 byte count readback", d, 12);
        fifo_step(); fifo_step();
        rd(8'h10, d); chk("R8 not yet zero", d, 0);
        fifo_step();
        rd(8'h10, d); chk("R8 reaches zero", d, 32'h8);
        wr(8'h10, 32'h8);
        fifo_step();
        rd(8'h10, d); chk("R8 access at zero", d, 32'h8);
        wr(8'h10, 32'h8);
        wr(8'h04, 6);
        fifo_step();
        rd(8'h10, d); chk("R8 6 minus 4", d, 0);
        fifo_step();
        rd(8'h10, d); chk("R8 saturates", d, 32'h8);
        wr(8'h10, 32'h8);
        reg_wr_en = 1'b1; reg_addr = 8'h04; reg_wdata = 8; fifo_access = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; fifo_access = 1'b0;
        fifo_step();
        rd(8'h10, d); chk("R8 load beats step", d, 0);
        fifo_step();
        rd(8'h10, d); chk("R8 after load", d, 32'h8);
        wr(8'h10, 32'h8);
    endtask

    task automatic t_gctl();
        logic [31:0] d;
        wr(8'h00, 32'hA5A5_A5A7);
        rd(8'h00, d); chk("R9 self-clear bits", d, 32'hA5A5_A5A0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        pulse(7'b1000000);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d); chk("R10 status write ignored", d, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); chk("R10 unknown offset", d, 0);
        rd(8'h08, d); chk("R10 unknown write no effect", d, 0);
        pulse(7'b0100000);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R10 unimplemented bits", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_collision();
        t_irq();
        t_card();
        t_counter();
        t_gctl();
        t_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule